// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port word memory and decides, cycle by cycle, which port may touch a word that both ports address at the same time. Each port, called left and right, presents an enable, a word address and a write request. When both ports are enabled on the same address, one port keeps access and the other sees its active-low busy output pulled low. The losing port must hold back its write, wait for busy to rise, and then repeat its access.

Arbitration is done by a registered state machine with seven states. `ST_IDLE` means that no port owns a contended word. `ST_GRANT_L` and `ST_GRANT_R` are the first cycle of a new contention, owned by the left or the right port. `ST_HOLD_L` and `ST_HOLD_R` hold that owner while the match lasts. `ST_FREE_L` and `ST_FREE_R` are the single cycle in which the named former loser is released.

The transitions are as follows:
- *claim*: from idle or free, a match seen this cycle leads to a grant state.
- *keep*: from grant or hold, a continuing match leads to the hold state of the same side.
- *end*: from grant or hold, a lost match leads to the free state of the losing side.
- *settle*: from idle or free, no match leads to idle.

A port that arrives first wins. A port counts as "settled" when it was enabled on the same address in the previous cycle. If both ports arrive together, a one-bit preference decides the winner and then flips.

The block also gates the write request of each port in the same cycle as the match. This means that a losing write never reaches the array, not even in the first contended cycle. It also flags a losing reader whose winner is writing, because the data that reader sees may be stale.

Top module: `dpc_contention_arb`

## Requirements
- R1: While reset is held, and after it, both busy outputs are 1, both retry outputs and `clash_evt` are 0, and the tie preference points at the left port.
- R2: A match means both enables are 1 and the addresses are equal. When there is no match, both busy outputs stay 1, and each write go output equals that port's enable AND its write request.
- R3: `left_busy_n` and `right_busy_n` are never 0 in the same cycle.
- R4: When a match is first seen and exactly one port is settled (enabled on the same address in the previous cycle), the settled port wins. The other port's busy output goes to 0 in the next cycle.
- R5: When a match is first seen and both ports or neither port are settled, the tie goes to the preferred side, starting with left after reset. The preference then flips, so the next tie goes to the port that lost this one.
- R6: While the match continues, the owner never changes and the loser's busy output stays 0.
- R7: In the cycle after the match ends, the loser's busy output returns to 1 and its retry output is 1 for exactly that one cycle.
- R8: `clash_evt` is 1 for exactly one cycle, the first cycle in which a busy output is 0 for a new contention.
- R9: In every matching cycle, including the first one, the losing port's write go output is 0. The winning port's write go output follows its write request.
- R10: A losing port that is reading (write request 0), while the winner requests a write, has its stale output at 1 in that matching cycle. In every other case the stale output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_en | input | 1 | Left port enable |
| left_addr | input | ADDR_W | Left port word address |
| left_wr | input | 1 | Left port write request |
| right_en | input | 1 | Right port enable |
| right_addr | input | ADDR_W | Right port word address |
| right_wr | input | 1 | Right port write request |
| left_busy_n | output | 1 | Left port must wait (active low, registered) |
| right_busy_n | output | 1 | Right port must wait (active low, registered) |
| left_retry | output | 1 | One-cycle pulse: left port may repeat its access |
| right_retry | output | 1 | One-cycle pulse: right port may repeat its access |
| clash_evt | output | 1 | One-cycle pulse at the start of a contention |
| left_wr_go | output | 1 | Left write allowed to reach the array this cycle |
| right_wr_go | output | 1 | Right write allowed to reach the array this cycle |
| left_stale | output | 1 | Left read data may be stale this cycle |
| right_stale | output | 1 | Right read data may be stale this cycle |

## Verification
Two functions can fall in the same cycle. The first is a new claim decided by arrival order or by the tie preference, which gates the loser's write combinationally. The second is the one-cycle release of the previous loser in a free state. The bench provokes this overlap by holding one port on an address while the other port leaves and returns within a single cycle, and by steering random traffic over a four-word window so that free states are often followed at once by a fresh claim. A behavioural reference model checks every cycle that the retry pulse, the new grant's gating of the write and the flip of the tie preference all agree with the requirements.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    // Arbiter states. FREE_x names the side that is being released.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GRANT_L = 3'd1,
        ST_GRANT_R = 3'd2,
        ST_HOLD_L  = 3'd3,
        ST_HOLD_R  = 3'd4,
        ST_FREE_L  = 3'd5,
        ST_FREE_R  = 3'd6
    } arb_state_t;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_t;

    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/dpc_arrival.sv
// Marks a port as settled when it held the same enabled address last cycle.
module dpc_arrival #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              settled
);
    logic              prev_en_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_en_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_en_q   <= en;
            prev_addr_q <= addr;
        end
    end

    assign settled = en && prev_en_q && (addr == prev_addr_q);

endmodule

// File: rtl/dpc_match.sv
// Contention exists only when both ports are enabled on the same word.
module dpc_match #(
    parameter int ADDR_W = 11
) (
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              match
);
    assign match = l_en && r_en && (l_addr == r_addr);
endmodule

// File: rtl/dpc_tiebrk.sv
// One-bit rotating preference for simultaneous arrivals.
module dpc_tiebrk
    import dpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tie_take,
    output side_t pref
);
    side_t pref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pref_q <= SIDE_L;
        end else if (tie_take) begin
            pref_q <= (pref_q == SIDE_L) ? SIDE_R : SIDE_L;
        end
    end

    assign pref = pref_q;

    // R5: a consumed tie hands the next tie to the other side
    p_pref_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tie_take |=> (pref != $past(pref)));

    // R1: preference starts at the left side
    p_pref_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (pref == SIDE_L));

endmodule

// File: rtl/dpc_fsm.sv
// Ownership state machine: registered state, combinational outputs.
module dpc_fsm
    import dpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  match,
    input  logic  settled_l,
    input  logic  settled_r,
    input  side_t pref,
    input  logic  l_en,
    input  logic  l_wr,
    input  logic  r_en,
    input  logic  r_wr,
    output logic  tie_take,
    output logic  l_busy_n,
    output logic  r_busy_n,
    output logic  l_retry,
    output logic  r_retry,
    output logic  clash_evt,
    output logic  l_wr_go,
    output logic  r_wr_go,
    output logic  l_stale,
    output logic  r_stale
);
    arb_state_t state_q, state_d;
    side_t      fresh_win, cur_win;
    logic       fresh, lose_l, lose_r;

    // Winner selection for a new contention
    always_comb begin
        fresh = (state_q == ST_IDLE) || (state_q == ST_FREE_L) ||
                (state_q == ST_FREE_R);
        if (settled_l && !settled_r) begin
            fresh_win = SIDE_L;
        end else if (settled_r && !settled_l) begin
            fresh_win = SIDE_R;
        end else begin
            fresh_win = pref;
        end
        tie_take = fresh && match && (settled_l == settled_r);
    end

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_FREE_L, ST_FREE_R: begin
                if (match) begin
                    state_d = (fresh_win == SIDE_L) ? ST_GRANT_L : ST_GRANT_R;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_GRANT_L, ST_HOLD_L: state_d = match ? ST_HOLD_L : ST_FREE_R;
            ST_GRANT_R, ST_HOLD_R: state_d = match ? ST_HOLD_R : ST_FREE_L;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        l_busy_n  = 1'b1;
        r_busy_n  = 1'b1;
        l_retry   = 1'b0;
        r_retry   = 1'b0;
        clash_evt = 1'b0;
        cur_win   = fresh_win;
        unique case (state_q)
            ST_GRANT_L: begin r_busy_n = 1'b0; clash_evt = 1'b1; cur_win = SIDE_L; end
            ST_GRANT_R: begin l_busy_n = 1'b0; clash_evt = 1'b1; cur_win = SIDE_R; end
            ST_HOLD_L:  begin r_busy_n = 1'b0; cur_win = SIDE_L; end
            ST_HOLD_R:  begin l_busy_n = 1'b0; cur_win = SIDE_R; end
            ST_FREE_L:  l_retry = 1'b1;
            ST_FREE_R:  r_retry = 1'b1;
            default:    ;
        endcase
        lose_l  = match && (cur_win == SIDE_R);
        lose_r  = match && (cur_win == SIDE_L);
        l_wr_go = l_en && l_wr && !lose_l;
        r_wr_go = r_en && r_wr && !lose_r;
        l_stale = l_en && !l_wr && lose_l && r_wr;
        r_stale = r_en && !r_wr && lose_r && l_wr;
    end

    // R3: the two busy outputs are never low together
    p_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    // R4: a busy output only falls after a match was present
    p_busy_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_busy_n) |-> $past(match));

    // R6: owner kept while the match lasts
    p_owner_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && match) |=> (!r_busy_n && l_busy_n));

    // R7: busy release comes with a single retry pulse
    p_retry_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_busy_n) |-> l_retry);
    p_retry_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_retry |=> !r_retry);

    // R8: clash pulse marks a fresh busy assertion
    p_clash_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clash_evt |-> ($fell(l_busy_n) || $fell(r_busy_n)));

    // R9: a waiting port never writes while the match lasts
    p_wr_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && match) |-> !l_wr_go);

    // R10: stale flag only on a reader
    p_stale_reader_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_stale |-> (!r_wr && !r_wr_go));

endmodule

// File: rtl/dpc_contention_arb.sv
module dpc_contention_arb
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_en,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              left_wr,
    input  logic              right_en,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              right_wr,
    output logic              left_busy_n,
    output logic              right_busy_n,
    output logic              left_retry,
    output logic              right_retry,
    output logic              clash_evt,
    output logic              left_wr_go,
    output logic              right_wr_go,
    output logic              left_stale,
    output logic              right_stale
);
    logic              en_v      [NUM_SIDES];
    logic [ADDR_W-1:0] addr_v    [NUM_SIDES];
    logic              settled_v [NUM_SIDES];
    logic              match;
    logic              tie_take;
    side_t             pref;

    assign en_v[0]   = left_en;
    assign en_v[1]   = right_en;
    assign addr_v[0] = left_addr;
    assign addr_v[1] = right_addr;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_arr
        dpc_arrival #(.ADDR_W(ADDR_W)) u_arr (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (en_v[s]),
            .addr    (addr_v[s]),
            .settled (settled_v[s])
        );
    end

    dpc_match #(.ADDR_W(ADDR_W)) u_match (
        .l_en   (left_en),
        .l_addr (left_addr),
        .r_en   (right_en),
        .r_addr (right_addr),
        .match  (match)
    );

    dpc_tiebrk u_tie (
        .clk      (clk),
        .rst_n    (rst_n),
        .tie_take (tie_take),
        .pref     (pref)
    );

    dpc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .settled_l (settled_v[0]),
        .settled_r (settled_v[1]),
        .pref      (pref),
        .l_en      (left_en),
        .l_wr      (left_wr),
        .r_en      (right_en),
        .r_wr      (right_wr),
        .tie_take  (tie_take),
        .l_busy_n  (left_busy_n),
        .r_busy_n  (right_busy_n),
        .l_retry   (left_retry),
        .r_retry   (right_retry),
        .clash_evt (clash_evt),
        .l_wr_go   (left_wr_go),
        .r_wr_go   (right_wr_go),
        .l_stale   (left_stale),
        .r_stale   (right_stale)
    );

    // R2: no busy without an earlier match of enabled ports
    p_no_match_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(match) && !$past(match, 2) && $past(rst_n, 2))
            |-> (left_busy_n && right_busy_n));

endmodule

// File: tb/sim_dpc_contention_arb.sv
module sim_dpc_contention_arb;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          le = 0, lw = 0, re = 0, rw = 0;
    logic [AW-1:0] la = '0, ra = '0;
    logic lb, rb, lrt, rrt, clash, lgo, rgo, lst, rst_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dpc_contention_arb #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .left_en(le), .left_addr(la), .left_wr(lw),
        .right_en(re), .right_addr(ra), .right_wr(rw),
        .left_busy_n(lb), .right_busy_n(rb),
        .left_retry(lrt), .right_retry(rrt), .clash_evt(clash),
        .left_wr_go(lgo), .right_wr_go(rgo),
        .left_stale(lst), .right_stale(rst_o)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: 0 none, 1 left, 2 right
    int m_own = 0, m_freed = 0, m_pref = 1;
    bit m_first = 0;
    bit pl_en = 0, pr_en = 0;
    logic [AW-1:0] pl_a = '0, pr_a = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_own = 0; m_freed = 0; m_pref = 1; m_first = 0;
            pl_en = 0; pr_en = 0; pl_a = '0; pr_a = '0;
        end else begin
            bit mt, sl, sr;
            int win;
            mt = le && re && (la == ra);
            sl = le && pl_en && (la == pl_a);
            sr = re && pr_en && (ra == pr_a);
            if (m_own != 0) win = m_own;
            else if (sl && !sr) win = 1;
            else if (sr && !sl) win = 2;
            else win = m_pref;
            chk("R3 busy exclusive", !(!lb && !rb), 1'b1);
            chk("R4/R6 left busy", lb, !(m_own == 2));
            chk("R4/R6 right busy", rb, !(m_own == 1));
            chk("R7 left retry", lrt, m_freed == 1);
            chk("R7 right retry", rrt, m_freed == 2);
            chk("R8 clash", clash, (m_own != 0) && m_first);
            chk("R9 left wr go", lgo, le && lw && !(mt && win == 2));
            chk("R9 right wr go", rgo, re && rw && !(mt && win == 1));
            chk("R10 left stale", lst, le && !lw && mt && win == 2 && rw);
            chk("R10 right stale", rst_o, re && !rw && mt && win == 1 && lw);
            if (mt) begin
                if (m_own == 0) begin
                    if (sl == sr) m_pref = (m_pref == 1) ? 2 : 1;
                    m_own = win;
                    m_first = 1;
                end else begin
                    m_first = 0;
                end
                m_freed = 0;
            end else begin
                m_freed = (m_own == 1) ? 2 : (m_own == 2) ? 1 : 0;
                m_own = 0;
                m_first = 0;
            end
            pl_en = le; pl_a = la; pr_en = re; pr_a = ra;
        end
    end

    task automatic drive(bit l_e, int l_a, bit l_w, bit r_e, int r_a, bit r_w);
        @(posedge clk);
        #1;
        le = l_e; la = AW'(l_a); lw = l_w;
        re = r_e; ra = AW'(r_a); rw = r_w;
    endtask

    task automatic mid();
        @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        #2;
        chk("R1 left busy in reset", lb, 1'b1);
        chk("R1 right busy in reset", rb, 1'b1);
        chk("R1 retry in reset", lrt | rrt, 1'b0);
        chk("R1 clash in reset", clash, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        drive(0, 0, 0, 0, 0, 0);
        mid();
        chk("R1 busy after reset", lb & rb, 1'b1);

        // R5: first tie goes left, both writing
        drive(1, 5, 1, 1, 5, 1); mid();
        chk("R5 first tie left write passes", lgo, 1'b1);
        chk("R9 loser write blocked in first cycle", rgo, 1'b0);
        drive(1, 5, 1, 1, 5, 1); mid();
        chk("R5 right flagged busy", rb, 1'b0);
        chk("R8 clash pulse", clash, 1'b1);
        drive(1, 5, 1, 1, 5, 1); mid();
        chk("R6 right still busy", rb, 1'b0);
        chk("R8 clash single cycle", clash, 1'b0);
        drive(1, 5, 1, 1, 6, 1); mid();
        chk("R7 busy still low in end cycle", rb, 1'b0);
        chk("R2 no match write passes", rgo, 1'b1);
        drive(0, 0, 0, 0, 0, 0); mid();
        chk("R7 right busy released", rb, 1'b1);
        chk("R7 right retry pulse", rrt, 1'b1);
        drive(0, 0, 0, 0, 0, 0); mid();
        chk("R7 retry one cycle", rrt, 1'b0);

        // R5: second tie goes right
        drive(1, 9, 0, 1, 9, 0);
        drive(1, 9, 0, 1, 9, 0); mid();
        chk("R5 second tie left busy", lb, 1'b0);
        chk("R5 second tie right free", rb, 1'b1);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);

        // R4: settled left reader beats newly arriving right writer
        drive(1, 3, 0, 0, 0, 0);
        drive(1, 3, 0, 1, 3, 1); mid();
        chk("R4 late writer blocked", rgo, 1'b0);
        chk("R10 winning reader not stale", lst, 1'b0);
        drive(1, 3, 0, 1, 3, 1); mid();
        chk("R4 late port busy", rb, 1'b0);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);

        // R10: settled right writer beats late left reader
        drive(0, 0, 0, 1, 7, 1);
        drive(1, 7, 0, 1, 7, 1); mid();
        chk("R10 losing reader stale", lst, 1'b1);
        chk("R9 winner write passes", rgo, 1'b1);
        drive(1, 7, 0, 1, 7, 1); mid();
        chk("R4 late reader busy", lb, 1'b0);
        chk("R10 still stale", lst, 1'b1);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);

        // R2: different addresses, one enable low
        drive(1, 4, 1, 1, 8, 1); mid();
        chk("R2 left write different addr", lgo, 1'b1);
        chk("R2 right write different addr", rgo, 1'b1);
        drive(1, 4, 1, 0, 4, 1); mid();
        chk("R2 disabled right no write", rgo, 1'b0);
        drive(1, 4, 1, 0, 4, 1); mid();
        chk("R2 no busy when enable low", lb & rb, 1'b1);

        // Random traffic over a small window
        for (int i = 0; i < 4000; i++) begin
            bit hold_l, hold_r;
            hold_l = ($urandom_range(0, 2) != 0);
            hold_r = ($urandom_range(0, 2) != 0);
            drive(hold_l ? le : 1'($urandom_range(0, 3) != 0),
                  hold_l ? int'(la) : $urandom_range(0, 3),
                  1'($urandom_range(0, 1)),
                  hold_r ? re : 1'($urandom_range(0, 3) != 0),
                  hold_r ? int'(ra) : $urandom_range(0, 3),
                  1'($urandom_range(0, 1)));
        end
        drive(0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule